// File: doc/BRIEF.md
# Dynamic Phase Step Controller

This block is the digital control half of a variable clock phase shifter. It keeps a signed position, counted in delay-line taps, that says how far the output clock is shifted. While the clock-management logic reports lock, a caller can request a single step in either direction. The block works out the new position, waits a settle time that the caller sets (this stands in for the analog delay line), and then raises a one-cycle done pulse. Only after that pulse can the next request be taken.

The position can move only within a symmetric window. The width of that window comes from the period of the reference clock, which is a parameter. If the period is no longer than the delay line's guaranteed span, the window is ±255 taps. Otherwise the line cannot cover a full period, and the window shrinks to the whole-number part of 256 × span / period. An overflow status bit goes high when a step lands on either edge of the window. It stays high while the position sits on that edge and clears when a later step moves the position inward. On reset the position goes back to its configured starting value.

The interface is plain control and status only. No data stream flows through the block, so it has no valid/ready pair. A request is a one-cycle pulse, and the done pulse is the only handshake.

Top module: `phase_step_ctrl`

## Requirements
- R1: Each accepted request changes `tap_pos` by exactly one tap, or by none at a window edge. `step_up`=1 at acceptance means +1 and `step_up`=0 means −1. The position never changes in a cycle where `step_done` is low.
- R2: Every accepted request produces exactly one `step_done` pulse, one cycle wide. `tap_pos` and `at_limit` already show the result in the cycle where the pulse is high.
- R3: While `rst` is high and right after it, `tap_pos` equals INIT_POS, `at_limit` is 0 and `step_done` is 0. An operation in progress when reset arrives is dropped.
- R4: If PERIOD_PS ≤ RANGE_PS, the position window is −255..+255 taps.
- R5: If PERIOD_PS > RANGE_PS, the window is ±floor(RANGE_PS × 256 / PERIOD_PS) taps. With a 20000 ps period and a 10000 ps span this is ±128.
- R6: `at_limit` goes to 1 when a step lands on +limit or −limit. It goes back to 0 when a later step leaves that edge.
- R7: A `step_req` sampled while `locked` is 0 is ignored: no done pulse follows and the position does not change.
- R8: A request that would push past an edge of the window leaves `tap_pos` unchanged and keeps `at_limit` at 1. It still produces a `step_done` pulse.
- R9: A `step_req` sampled while an operation is in progress, or in the cycle where `step_done` is high, is ignored.
- R10: `step_done` goes high max(`settle_cycles`, 2) clock edges after the edge that accepts the request. `settle_cycles` is sampled at acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Phase-shift control clock |
| rst | input | 1 | Asynchronous active-high reset; position returns to INIT_POS |
| locked | input | 1 | Lock indication; requests are taken only when high |
| step_req | input | 1 | One-cycle request for a single step |
| step_up | input | 1 | Direction sampled with the request: 1 increments, 0 decrements |
| settle_cycles | input | LAT_W | Settle latency in clock cycles; values below 2 act as 2 |
| step_done | output | 1 | One-cycle pulse marking the end of an operation |
| at_limit | output | 1 | Overflow status: position is on an edge of the window |
| tap_pos | output | POS_W | Signed current position in taps |

## Verification
The assertions assume that `locked` stays high for the whole time an operation is in progress, and that INIT_POS lies strictly inside the window. The stimulus meets both conditions. It drops `locked` only while the block is idle and no done pulse is pending. Both instances under test start a few taps inside their window edges. Requests, directions and latencies are driven on the falling edge, so the block sees a clean value at each rising edge.

// File: rtl/phase_step_pkg.sv
package phase_step_pkg;

  typedef enum logic {
    DIR_DOWN = 1'b0,
    DIR_UP   = 1'b1
  } step_dir_e;

  // Window half-width in taps for a given reference period and delay-line span.
  function automatic longint window_taps(input longint period_ps,
                                         input longint range_ps,
                                         input longint tap_span);
    if (period_ps <= range_ps) return tap_span - 1;
    return (range_ps * tap_span) / period_ps;
  endfunction

endpackage

// File: rtl/step_limit_calc.sv
module step_limit_calc #(
  parameter int POS_W     = 10,
  parameter int PERIOD_PS = 8000,
  parameter int RANGE_PS  = 10000,
  parameter int TAP_SPAN  = 256
) (
  output logic signed [POS_W-1:0] limit_o
);
  import phase_step_pkg::*;

  generate
    if (PERIOD_PS <= RANGE_PS) begin : g_full_period
      // The line covers a whole period: the limit is the last tap.
      localparam longint FULL_LIM = longint'(TAP_SPAN) - 1;
      assign limit_o = POS_W'(FULL_LIM);
    end else begin : g_partial_period
      // Long period: only part of it can be reached.
      localparam longint PART_LIM = window_taps(PERIOD_PS, RANGE_PS, TAP_SPAN);
      assign limit_o = POS_W'(PART_LIM);
    end
  endgenerate

endmodule

// File: rtl/step_settle_timer.sv
module step_settle_timer #(
  parameter int LAT_W   = 6,
  parameter int LAT_MIN = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [LAT_W-1:0] cfg,
  output logic             busy_o,
  output logic             fire_o
);
  localparam logic [LAT_W-1:0] MIN_V = LAT_W'(LAT_MIN);
  localparam logic [LAT_W-1:0] ONE_V = LAT_W'(1);

  logic [LAT_W-1:0] cnt;
  logic [LAT_W-1:0] eff_lat;

  assign eff_lat = (cfg < MIN_V) ? MIN_V : cfg;
  assign fire_o  = busy_o && (cnt == ONE_V);

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      cnt    <= '0;
      busy_o <= 1'b0;
    end else if (start) begin
      cnt    <= eff_lat;
      busy_o <= 1'b1;
    end else if (busy_o) begin
      cnt <= cnt - ONE_V;
      if (cnt == ONE_V) busy_o <= 1'b0;
    end
  end

endmodule

// File: rtl/step_pos_track.sv
module step_pos_track #(
  parameter int POS_W    = 10,
  parameter int INIT_POS = 0
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    apply,
  input  phase_step_pkg::step_dir_e dir,
  input  logic signed [POS_W-1:0] limit_i,
  output logic signed [POS_W-1:0] pos_o,
  output logic                    ovf_o,
  output logic                    done_o
);
  import phase_step_pkg::*;

  localparam logic signed [POS_W-1:0] INIT_V = POS_W'(INIT_POS);

  logic signed [POS_W-1:0] neg_lim;
  logic signed [POS_W-1:0] nxt_pos;
  logic                    hi_edge;
  logic                    lo_edge;
  logic                    nxt_edge;

  always_comb begin
    neg_lim = -limit_i;
    hi_edge = (pos_o >= limit_i);
    lo_edge = (pos_o <= neg_lim);
    if (dir == DIR_UP) nxt_pos = hi_edge ? pos_o : pos_o + POS_W'(1);
    else               nxt_pos = lo_edge ? pos_o : pos_o - POS_W'(1);
    nxt_edge = (nxt_pos == limit_i) || (nxt_pos == neg_lim);
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      pos_o  <= INIT_V;
      ovf_o  <= 1'b0;
      done_o <= 1'b0;
    end else begin
      done_o <= apply;
      if (apply) begin
        pos_o <= nxt_pos;
        ovf_o <= nxt_edge;
      end
    end
  end

endmodule

// File: rtl/phase_step_ctrl.sv
module phase_step_ctrl #(
  parameter int POS_W     = 10,
  parameter int LAT_W     = 6,
  parameter int PERIOD_PS = 8000,
  parameter int RANGE_PS  = 10000,
  parameter int TAP_SPAN  = 256,
  parameter int INIT_POS  = 0
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    locked,
  input  logic                    step_req,
  input  logic                    step_up,
  input  logic [LAT_W-1:0]        settle_cycles,
  output logic                    step_done,
  output logic                    at_limit,
  output logic signed [POS_W-1:0] tap_pos
);
  import phase_step_pkg::*;

  logic signed [POS_W-1:0] lim;
  logic                    op_busy;
  logic                    op_fire;
  logic                    accept;
  step_dir_e               op_dir;

  step_limit_calc #(
    .POS_W(POS_W), .PERIOD_PS(PERIOD_PS), .RANGE_PS(RANGE_PS), .TAP_SPAN(TAP_SPAN)
  ) u_limit (
    .limit_o(lim)
  );

  assign accept = step_req && locked && !op_busy && !step_done;

  always_ff @(posedge clk or posedge rst) begin
    if (rst)         op_dir <= DIR_DOWN;
    else if (accept) op_dir <= step_up ? DIR_UP : DIR_DOWN;
  end

  step_settle_timer #(.LAT_W(LAT_W), .LAT_MIN(2)) u_timer (
    .clk(clk), .rst(rst), .start(accept), .cfg(settle_cycles),
    .busy_o(op_busy), .fire_o(op_fire)
  );

  step_pos_track #(.POS_W(POS_W), .INIT_POS(INIT_POS)) u_track (
    .clk(clk), .rst(rst), .apply(op_fire), .dir(op_dir), .limit_i(lim),
    .pos_o(tap_pos), .ovf_o(at_limit), .done_o(step_done)
  );

endmodule

// File: rtl/phase_step_chk.sv
module phase_step_chk #(
  parameter int POS_W = 10
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    locked,
  input logic                    busy,
  input logic                    step_done,
  input logic                    at_limit,
  input logic signed [POS_W-1:0] tap_pos,
  input logic signed [POS_W-1:0] lim
);

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    step_done |=> !step_done); // R2

  AST_POS_QUIET: assert property (@(posedge clk) disable iff (rst)
    !step_done |-> $stable(tap_pos)); // R1

  AST_POS_UNIT: assert property (@(posedge clk) disable iff (rst)
    step_done |-> ((tap_pos - $past(tap_pos) <= 1) && ($past(tap_pos) - tap_pos <= 1))); // R1

  AST_POS_WINDOW: assert property (@(posedge clk) disable iff (rst)
    (tap_pos <= lim) && (tap_pos >= -lim)); // R4

  AST_OVF_ON_DONE: assert property (@(posedge clk) disable iff (rst)
    $changed(at_limit) |-> step_done); // R6

  AST_LOCK_HELD: assert property (@(posedge clk) disable iff (rst)
    busy |-> locked); // R7

  AST_MIN_SETTLE: assert property (@(posedge clk) disable iff (rst)
    step_done |-> ($past(busy, 1) && $past(busy, 2))); // R10

endmodule

bind phase_step_ctrl phase_step_chk #(.POS_W(POS_W)) u_chk (
  .clk(clk), .rst(rst), .locked(locked), .busy(op_busy),
  .step_done(step_done), .at_limit(at_limit), .tap_pos(tap_pos), .lim(lim)
);

// File: tb/phase_step_ctrl_test.sv
`timescale 1ns/1ps
module phase_step_ctrl_test;
  localparam int POS_W = 10;
  localparam int LAT_W = 6;
  localparam int LIM_A = 255;   // 8000 ps period, full span
  localparam int LIM_B = 128;   // 20000 ps period: floor(10000*256/20000)
  localparam int INIT_A = 250;
  localparam int INIT_B = -120;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic locked = 1'b1;
  logic step_req = 1'b0;
  logic step_up = 1'b0;
  logic [LAT_W-1:0] settle_cycles = '0;
  logic done_a, done_b, ovf_a, ovf_b;
  logic signed [POS_W-1:0] pos_a, pos_b;

  int n_chk = 0;
  int n_bad = 0;
  int exp_a = INIT_A;
  int exp_b = INIT_B;
  bit fin = 1'b0;

  always #2 clk = ~clk;

  phase_step_ctrl #(.POS_W(POS_W), .LAT_W(LAT_W), .PERIOD_PS(8000),
                    .INIT_POS(INIT_A)) uut (
    .clk(clk), .rst(rst), .locked(locked), .step_req(step_req), .step_up(step_up),
    .settle_cycles(settle_cycles), .step_done(done_a), .at_limit(ovf_a), .tap_pos(pos_a));

  phase_step_ctrl #(.POS_W(POS_W), .LAT_W(LAT_W), .PERIOD_PS(20000),
                    .INIT_POS(INIT_B)) uut_slow (
    .clk(clk), .rst(rst), .locked(locked), .step_req(step_req), .step_up(step_up),
    .settle_cycles(settle_cycles), .step_done(done_b), .at_limit(ovf_b), .tap_pos(pos_b));

  function automatic int next_pos(input int p, input bit up, input int lim);
    if (up) return (p >= lim) ? p : p + 1;
    return (p <= -lim) ? p : p - 1;
  endfunction

  function automatic int edge_flag(input int p, input int lim);
    return ((p == lim) || (p == -lim)) ? 1 : 0;
  endfunction

  function automatic int eff_lat(input int l);
    return (l < 2) ? 2 : l;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_state(input string req);
    check(int'(pos_a) == exp_a, {req, " pos A"}, int'(pos_a), exp_a);
    check(int'(pos_b) == exp_b, {req, " pos B"}, int'(pos_b), exp_b);
    check(int'(ovf_a) == edge_flag(exp_a, LIM_A), {req, " ovf A"}, int'(ovf_a), edge_flag(exp_a, LIM_A));
    check(int'(ovf_b) == edge_flag(exp_b, LIM_B), {req, " ovf B"}, int'(ovf_b), edge_flag(exp_b, LIM_B));
  endtask

  // One full operation with latency measurement (R10) and result check (R1/R2).
  task automatic do_step(input bit up, input int lat);
    int c;
    @(negedge clk);
    step_req = 1'b1; step_up = up; settle_cycles = LAT_W'(lat);
    @(negedge clk);
    step_req = 1'b0;
    c = 0;
    while (!done_a && c < 64) begin @(negedge clk); c++; end
    check(c == eff_lat(lat), "R10 latency", c, eff_lat(lat));
    check(done_b == 1'b1, "R2 done B", int'(done_b), 1);
    exp_a = next_pos(exp_a, up, LIM_A);
    exp_b = next_pos(exp_b, up, LIM_B);
    check_state("R1/R6/R8");
    @(negedge clk);
    check(done_a == 1'b0, "R2 single pulse", int'(done_a), 0);
  endtask

  task automatic count_done(input int cycles, output int n);
    n = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (done_a) n++;
    end
  endtask

  initial begin
    int nd;
    void'($urandom(32'd7151));
    repeat (3) @(negedge clk);
    check_state("R3 reset");
    check(done_a == 1'b0, "R3 done idle", int'(done_a), 0);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);

    // R4 / R6 / R8: reach the +255 edge of A, then push past it.
    for (int i = 0; i < 6; i++) do_step(1'b1, 3);
    check(ovf_a == 1'b1, "R8 ovf held at edge", int'(ovf_a), 1);
    do_step(1'b0, 2);
    check(ovf_a == 1'b0, "R6 ovf clears", int'(ovf_a), 0);

    // R5: B reaches -128 and stays; latencies 0 and 1 act as 2.
    for (int i = 0; i < 16; i++) do_step(1'b0, i % 4);
    check(int'(pos_b) == -LIM_B, "R5 B lower edge", int'(pos_b), -LIM_B);
    do_step(1'b1, 5);

    // R9: a second pulse during the operation is ignored.
    @(negedge clk); step_req = 1'b1; step_up = 1'b1; settle_cycles = 6'd6;
    @(negedge clk); step_req = 1'b0;
    @(negedge clk); step_req = 1'b1; step_up = 1'b0;
    @(negedge clk); step_req = 1'b0;
    count_done(20, nd);
    check(nd == 1, "R9 busy ignore", nd, 1);
    exp_a = next_pos(exp_a, 1'b1, LIM_A);
    exp_b = next_pos(exp_b, 1'b1, LIM_B);
    check_state("R9");

    // R9: a request held for four edges; the one on the done edge is ignored.
    @(negedge clk); step_req = 1'b1; step_up = 1'b1; settle_cycles = 6'd2;
    repeat (4) @(negedge clk);
    step_req = 1'b0;
    count_done(12, nd);
    exp_a = next_pos(exp_a, 1'b1, LIM_A);
    exp_b = next_pos(exp_b, 1'b1, LIM_B);
    check(nd == 0, "R9 done cycle ignore", nd, 0);
    check_state("R9 held");

    // R7: requests while unlocked are ignored.
    @(negedge clk); locked = 1'b0; step_req = 1'b1; step_up = 1'b1;
    @(negedge clk); step_req = 1'b0;
    count_done(10, nd);
    check(nd == 0, "R7 unlocked", nd, 0);
    check_state("R7");
    locked = 1'b1;

    // Random walk against the model.
    for (int i = 0; i < 250; i++) do_step(1'($urandom % 2), int'($urandom % 8));

    // R3: reset during an operation.
    @(negedge clk); step_req = 1'b1; step_up = 1'b0; settle_cycles = 6'd9;
    @(negedge clk); step_req = 1'b0;
    @(negedge clk); rst = 1'b1;
    exp_a = INIT_A; exp_b = INIT_B;
    @(negedge clk); check_state("R3 mid-op reset");
    rst = 1'b0;
    count_done(15, nd);
    check(nd == 0, "R3 op dropped", nd, 0);
    check_state("R3 after");

    if (!fin) begin
      fin = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!fin) begin
      fin = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

endmodule